// File: doc/BRIEF.md
# K-line Transmit Path Guard

This block sits between a serial protocol controller and a single-wire K-line driver. It decides, cycle by cycle, whether the controller's transmit data may reach the line. Two faults can close the path. The first is an echo mismatch, where the debounced bus level differs from the transmitted bit for too long. The second is a stuck-low transmit line, where TxD stays low too long in total. The path reopens only after transmit data and bus have both been high for a qualification time. The receive level is passed through untouched whatever the transmit state.

A shared status/override pin is modelled as two inputs: a drive flag and a driven value. When something external drives the pin, its value forces the path open (0) or closed (1), and the autonomous checks are held in their disabled, cleared state. When nothing drives the pin, the block drives it as a status output: 0 means the path is open and 1 means it is closed.

All times are counted in clock cycles and set by parameters. The echo window is `T_BC`, the qualification window is `T_ENA`, the stuck-low limit is `T_LOW` and the high run that clears the stuck-low accumulator is `T_REC`. `T_BC` is meant to be much smaller than `T_LOW`.

Top module: `kline_tx_guard`

## Requirements
- R1: While reset is asserted and right after its release, the driver enable is 0, the bus drive output is 1 (recessive) and the status level is 1.
- R2: With no override, once TxD and the bus level have both been sampled high on `T_ENA` consecutive clock edges, the driver enable becomes 1 from that edge on.
- R3: With no override, if TxD and the bus level differ on `T_BC` consecutive edges, the driver enable becomes 0 from that edge on; a mismatch run of `T_BC-1` edges leaves it enabled.
- R4: With no override, once TxD has been sampled low on `T_LOW` edges since the accumulator was last cleared, the driver enable becomes 0 from that edge on.
- R5: A TxD high run of at least `T_REC` edges clears the stuck-low accumulator, and so does a re-enable event. A shorter high run leaves the accumulated low count unchanged.
- R6: After any shutdown, the path stays closed until TxD and the bus are both high for `T_ENA` consecutive edges.
- R7: While the override pin is driven, the driver enable equals the inverse of the driven value in the same cycle (0 forces it open, 1 forces it closed), whatever TxD and the bus do.
- R8: While the override pin is driven, the autonomous state is held closed with all timers cleared. After release the path stays closed until the `T_ENA` condition holds.
- R9: The status drive flag equals the inverse of the override drive input. The status level is 0 when the autonomous path is open and 1 when it is closed.
- R10: The bus drive output equals TxD while the driver is enabled and is 1 while it is disabled.
- R11: The receive output always equals the bus level input, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timers count its rising edges |
| rstN | input | 1 | Active-low synchronous reset |
| txd | input | 1 | Transmit data from the protocol controller |
| busLvl | input | 1 | Debounced level read back from the K-line |
| ovrDrive | input | 1 | 1 when an external source drives the status/override pin |
| ovrVal | input | 1 | Value on the pin while externally driven (0 open, 1 closed) |
| drvEn | output | 1 | Enable for the line driver |
| busOut | output | 1 | Data to the line driver, recessive 1 when disabled |
| statusOut | output | 1 | Status level for the pin: 0 open, 1 closed |
| statusOe | output | 1 | 1 when the block drives the status pin |
| rxdOut | output | 1 | Receive data to the protocol controller |

## Verification
The override, bus drive, status drive flag and receive outputs are combinational, so they are due in the same cycle as the input change. The enable decision is a register, so it changes on the edge that takes in the last qualifying sample (the `T_BC`-th mismatch, the `T_LOW`-th low or the `T_ENA`-th high pair). Inputs are applied shortly after a rising edge and all outputs are sampled on the falling edge. Each output is compared on every falling edge with a behavioural model that is updated on the rising edge. The scenario checks pick cycle counts just short of and just past each window, so an off-by-one in any timer shows up.

// File: rtl/txg_pkg.sv
package txg_pkg;
  // strobes from control to the timer datapath
  typedef struct packed {
    logic clrAll;   // hold every timer cleared (override active)
    logic clrLow;   // clear the stuck-low accumulator (re-enable event)
  } txgStrobe_t;

  // window-complete flags from the datapath to control
  typedef struct packed {
    logic bcHit;    // mismatch window completes this cycle
    logic lowHit;   // stuck-low limit reached this cycle
    logic enaHit;   // qualification window completes this cycle
  } txgFlags_t;
endpackage

// File: rtl/txg_timers.sv
module txg_timers
  import txg_pkg::*;
#(
  parameter int T_BC  = 4,
  parameter int T_ENA = 16,
  parameter int T_LOW = 200,
  parameter int T_REC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txd,
  input  logic       busLvl,
  input  txgStrobe_t strobe,
  output txgFlags_t  flags
);
  localparam int BCW  = $clog2(T_BC + 1);
  localparam int ENW  = $clog2(T_ENA + 1);
  localparam int LOW  = $clog2(T_LOW + 1);
  localparam int RECW = $clog2(T_REC + 1);
  localparam logic [BCW-1:0]  BC_LAST  = BCW'(T_BC - 1);
  localparam logic [BCW-1:0]  BC_MAX   = BCW'(T_BC);
  localparam logic [ENW-1:0]  ENA_LAST = ENW'(T_ENA - 1);
  localparam logic [ENW-1:0]  ENA_MAX  = ENW'(T_ENA);
  localparam logic [LOW-1:0]  LOW_LAST = LOW'(T_LOW - 1);
  localparam logic [LOW-1:0]  LOW_MAX  = LOW'(T_LOW);
  localparam logic [RECW-1:0] REC_LAST = RECW'(T_REC - 1);
  localparam logic [RECW-1:0] REC_MAX  = RECW'(T_REC);

  logic [BCW-1:0]  mmCnt;
  logic [ENW-1:0]  enaCnt;
  logic [LOW-1:0]  lowCnt;
  logic [RECW-1:0] hiCnt;
  logic mismatch, bothHigh;

  assign mismatch = txd ^ busLvl;
  assign bothHigh = txd & busLvl;

  always_comb begin
    flags.bcHit  = mismatch & (mmCnt == BC_LAST);
    flags.lowHit = ~txd & (lowCnt == LOW_LAST);
    flags.enaHit = bothHigh & (enaCnt == ENA_LAST);
  end

  // echo mismatch run
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrAll)        mmCnt <= '0;
    else if (!mismatch)                mmCnt <= '0;
    else if (mmCnt != BC_MAX)          mmCnt <= mmCnt + 1'b1;
  end

  // both-high qualification run
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrAll)        enaCnt <= '0;
    else if (!bothHigh)                enaCnt <= '0;
    else if (enaCnt != ENA_MAX)        enaCnt <= enaCnt + 1'b1;
  end

  // TxD high run, used to qualify the accumulator clear
  always_ff @(posedge clk) begin
    if (!rstN)                         hiCnt <= '0;
    else if (!txd)                     hiCnt <= '0;
    else if (hiCnt != REC_MAX)         hiCnt <= hiCnt + 1'b1;
  end

  // stuck-low accumulator: short high pulses do not clear it
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrAll || strobe.clrLow) lowCnt <= '0;
    else if (!txd) begin
      if (lowCnt != LOW_MAX)           lowCnt <= lowCnt + 1'b1;
    end else if (hiCnt >= REC_LAST)    lowCnt <= '0;
  end

  p_low_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txd && !strobe.clrAll && !strobe.clrLow && hiCnt < REC_LAST) |=> (lowCnt == $past(lowCnt)));

  p_low_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txd && !strobe.clrAll && hiCnt >= REC_LAST) |=> (lowCnt == '0));

  p_mm_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!mismatch) |=> (mmCnt == '0));
endmodule

// File: rtl/txg_ctrl.sv
module txg_ctrl
  import txg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ovrDrive,
  input  txgFlags_t  flags,
  output txgStrobe_t strobe,
  output logic       autoEn
);
  always_comb begin
    strobe.clrAll = ovrDrive;
    strobe.clrLow = flags.enaHit;
  end

  // faults take priority over qualification
  always_ff @(posedge clk) begin
    if (!rstN || ovrDrive)                 autoEn <= 1'b0;
    else if (flags.bcHit || flags.lowHit)  autoEn <= 1'b0;
    else if (flags.enaHit)                 autoEn <= 1'b1;
  end

  p_bc_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (flags.bcHit && !ovrDrive) |=> !autoEn);

  p_low_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (flags.lowHit && !ovrDrive) |=> !autoEn);

  p_ena_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    (flags.enaHit && !flags.bcHit && !flags.lowHit && !ovrDrive) |=> autoEn);

  p_ovr_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovrDrive |=> !autoEn);

  p_rise_qual_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(autoEn) |-> $past(flags.enaHit));
endmodule

// File: rtl/kline_tx_guard.sv
module kline_tx_guard
  import txg_pkg::*;
#(
  parameter int T_BC  = 4,
  parameter int T_ENA = 16,
  parameter int T_LOW = 200,
  parameter int T_REC = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic txd,
  input  logic busLvl,
  input  logic ovrDrive,
  input  logic ovrVal,
  output logic drvEn,
  output logic busOut,
  output logic statusOut,
  output logic statusOe,
  output logic rxdOut
);
  txgStrobe_t strobe;
  txgFlags_t  flags;
  logic       autoEn;

  txg_timers #(.T_BC(T_BC), .T_ENA(T_ENA), .T_LOW(T_LOW), .T_REC(T_REC)) u_timers (
    .clk(clk), .rstN(rstN), .txd(txd), .busLvl(busLvl), .strobe(strobe), .flags(flags)
  );

  txg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ovrDrive(ovrDrive), .flags(flags), .strobe(strobe), .autoEn(autoEn)
  );

  assign drvEn     = ovrDrive ? ~ovrVal : autoEn;
  assign busOut    = drvEn ? txd : 1'b1;
  assign statusOut = ~autoEn;
  assign statusOe  = ~ovrDrive;
  assign rxdOut    = busLvl;

  p_recessive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !drvEn |-> busOut);

  p_rx_pass_r11: assert property (@(posedge clk) disable iff (!rstN)
    rxdOut == busLvl);

  p_force_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovrDrive |-> (drvEn != ovrVal));
endmodule

// File: tb/kline_tx_guard_tb.sv
module kline_tx_guard_tb;
  localparam int T_BC  = 4;
  localparam int T_ENA = 16;
  localparam int T_LOW = 200;
  localparam int T_REC = 8;

  logic clk = 0;
  logic rstN = 0;
  logic txd = 1, ovrDrive = 0, ovrVal = 0, forceBus = 0, forceVal = 1;
  logic busLvl;
  logic drvEn, busOut, statusOut, statusOe, rxdOut;

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign busLvl = forceBus ? forceVal : busOut;  // line echo

  kline_tx_guard #(.T_BC(T_BC), .T_ENA(T_ENA), .T_LOW(T_LOW), .T_REC(T_REC)) u_dut (
    .clk(clk), .rstN(rstN), .txd(txd), .busLvl(busLvl), .ovrDrive(ovrDrive), .ovrVal(ovrVal),
    .drvEn(drvEn), .busOut(busOut), .statusOut(statusOut), .statusOe(statusOe), .rxdOut(rxdOut)
  );

  // behavioural reference: run lengths as integers
  int mRun = 0, hRun = 0, lAcc = 0, qRun = 0;
  bit mEn = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; hRun = 0; lAcc = 0; qRun = 0; mEn = 0;
    end else begin
      bit bc, lw, eq;
      bc = (txd != busLvl) && (mRun == T_BC - 1);
      lw = !txd && (lAcc == T_LOW - 1);
      eq = txd && busLvl && (qRun == T_ENA - 1);
      if (ovrDrive) begin
        mRun = 0; lAcc = 0; qRun = 0; mEn = 0;
      end else begin
        if (eq) lAcc = 0;
        else if (!txd) lAcc = (lAcc < T_LOW) ? lAcc + 1 : lAcc;
        else if (hRun >= T_REC - 1) lAcc = 0;
        mRun = (txd != busLvl) ? ((mRun < T_BC) ? mRun + 1 : mRun) : 0;
        qRun = (txd && busLvl) ? ((qRun < T_ENA) ? qRun + 1 : qRun) : 0;
        if (bc || lw) mEn = 0;
        else if (eq) mEn = 1;
      end
      hRun = txd ? ((hRun < T_REC) ? hRun + 1 : hRun) : 0;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      logic eEn;
      eEn = ovrDrive ? !ovrVal : mEn;
      chk("R2/R3/R4/R7 model drvEn", drvEn, eEn);
      chk("R10 model busOut", busOut, eEn ? txd : 1'b1);
      chk("R9 model statusOut", statusOut, !mEn);
      chk("R9 model statusOe", statusOe, !ovrDrive);
      chk("R11 model rxdOut", rxdOut, busLvl);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R1 watchdog actual %0d expected <100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic waitNeg();
    @(negedge clk);
    #1;
  endtask

  initial begin
    step(3);
    waitNeg();
    chk("R1 reset drvEn", drvEn, 1'b0);
    chk("R1 reset busOut", busOut, 1'b1);
    chk("R1 reset statusOut", statusOut, 1'b1);
    @(posedge clk); #2 rstN = 1;
    // R2: qualification from reset
    step(T_ENA - 1); waitNeg();
    chk("R2 before window", drvEn, 1'b0);
    step(2); waitNeg();
    chk("R2 after window", drvEn, 1'b1);
    chk("R9 status open", statusOut, 1'b0);
    // R10/R11: traffic with echo
    for (int i = 0; i < 12; i++) begin
      txd = (i % 3) != 0;
      step(1 + i % 4);
      waitNeg();
      chk("R10 follow", busOut, txd);
      chk("R11 rx", rxdOut, busLvl);
    end
    txd = 1; step(T_ENA + 2);
    // R3: short mismatch tolerated, full window closes
    forceBus = 1; forceVal = 0; step(T_BC - 1);
    forceBus = 0; step(1); waitNeg();
    chk("R3 short mismatch", drvEn, 1'b1);
    forceBus = 1; step(T_BC + 1); forceBus = 0; waitNeg();
    chk("R3 mismatch closes", drvEn, 1'b0);
    chk("R9 status closed", statusOut, 1'b1);
    chk("R10 recessive", busOut, 1'b1);
    // R6: requalify
    step(T_ENA - 2); waitNeg();
    chk("R6 still closed", drvEn, 1'b0);
    step(3); waitNeg();
    chk("R6 reopened", drvEn, 1'b1);
    // R5: short high pulse does not clear the accumulator
    txd = 0; step(150); txd = 1; step(3); txd = 0; step(60); waitNeg();
    chk("R5 short pulse keeps count", drvEn, 1'b0);
    txd = 1; step(T_ENA + 2); waitNeg();
    chk("R6 reopened after low", drvEn, 1'b1);
    // R5: long high pulse clears it
    txd = 0; step(150); txd = 1; step(T_REC + 2); txd = 0; step(60); waitNeg();
    chk("R5 long pulse clears", drvEn, 1'b1);
    txd = 1; step(T_REC + 2);
    // R4: continuous low
    txd = 0; step(T_LOW - 1); waitNeg();
    chk("R4 below limit", drvEn, 1'b1);
    step(2); waitNeg();
    chk("R4 at limit", drvEn, 1'b0);
    // R7: override forces
    ovrDrive = 1; ovrVal = 0; #1;
    chk("R7 force open", drvEn, 1'b1);
    chk("R9 oe released", statusOe, 1'b0);
    forceBus = 1; forceVal = 1; step(T_LOW + 20); waitNeg();
    chk("R7 ignores faults", drvEn, 1'b1);
    ovrVal = 1; #1;
    chk("R7 force closed", drvEn, 1'b0);
    txd = 1; forceBus = 0; step(T_ENA + 4); waitNeg();
    chk("R8 held closed", drvEn, 1'b0);
    chk("R8 status closed", statusOut, 1'b1);
    // R8: release needs qualification
    ovrDrive = 0; step(T_ENA - 1); waitNeg();
    chk("R8 not yet open", drvEn, 1'b0);
    step(2); waitNeg();
    chk("R8 open after window", drvEn, 1'b1);
    step(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule